// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

A 16-bit free-running counter with a programmable modulus feeds a single channel. The channel either timestamps edges on an input pin (input capture), signals and toggles a pin when the counter reaches a programmed value (output compare), or drives a pulse-width modulated pin. The PWM can be edge-aligned, where the counter runs from zero up to the modulus and wraps. It can also be center-aligned, where the counter runs up to the modulus and back down to zero.

Two sticky flags record events: a channel flag, whose setting rule depends on the channel mode, and an overflow flag. Each flag is cleared only by a read of the status register followed by a write of zero, which protects against losing an event that arrives between the two steps. A simple single-cycle register port gives software access to the modulus, the channel value, the control bits and the flags. A level interrupt request combines each flag with its own enable.

Top module: `tmr_channel`

## Requirements
- R1: After reset the modulus reads 0xFFFF, the channel value, control and status read 0, `irq_o` and `pin_oe_o` are 0, and the counter starts at 0.
- R2: In every mode except center-aligned PWM, the counter steps from 0 up to the modulus and then wraps to 0. The cycle in which it wraps sets the overflow flag (status bit 1).
- R3: In center-aligned PWM (mode 3), the counter counts 0 up to the modulus and then back down to 0, giving a period of twice the modulus. The step from the modulus to the next lower value sets the overflow flag.
- R4: In input capture (mode 0), control bits [3:2] choose the trigger: 0 disabled, 1 rising, 2 falling, 3 either. The pin passes through a two-flop synchronizer. A selected edge copies the counter into the channel value register and sets the channel flag (status bit 0) at the third rising clock edge after the pin changes.
- R5: In output compare (mode 1), every cycle in which the counter equals the channel value sets the channel flag and toggles `pin_o`.
- R6: In edge-aligned PWM (mode 2), `pin_o` is high while the counter is below the channel value. The channel flag sets on the match that ends the high portion.
- R7: In center-aligned PWM, `pin_o` is high while the counter is below the channel value. The flag sets on both matches in each period, so with value v (0 < v < modulus) the output is high for 2v-1 cycles per period.
- R8: A flag clears only when a status read sees it set and a later write to the status register carries 0 in that bit. A write of 0 without the read, and a write of 1, leave the flag unchanged.
- R9: An event of a flag that occurs after the arming read, or in the cycle of the clearing write, leaves that flag set.
- R10: `irq_o` is high when (channel flag and control bit 4) or (overflow flag and control bit 5) holds.
- R11: Register addresses: 0 modulus, 1 channel value, 2 control ({ovf_ie, ch_ie, edge[1:0], mode[1:0]} in bits 5:0), 3 status. Reads are combinational. A capture in the same cycle as a write to the value register wins. `pin_oe_o` is high in every mode except input capture.
- R12: A modulus of 0 holds the counter at 0 and sets the overflow event in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms flag clearing) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational on `addr_i` |
| pin_i | input | 1 | Capture input pin, asynchronous |
| pin_o | output | 1 | Compare/PWM output pin |
| pin_oe_o | output | 1 | Output enable for the pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes and flag changes show on `rdata_o` one clock after the write edge, and `pin_o` in PWM modes follows the counter register in the same cycle. A pin change driven before a clock edge reaches the value register and flag on the third edge. The bench holds a cycle-accurate reference model that advances right after each rising edge, and it compares every output at the falling edge. Each latency is therefore checked in exactly the cycle it is due, and no check waits loosely.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_CAP  = 2'd0,
    MODE_CMP  = 2'd1,
    MODE_EPWM = 2'd2,
    MODE_CPWM = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } tmr_edge_e;

  typedef struct packed {
    logic      ovf_ie;
    logic      ch_ie;
    tmr_edge_e edge_sel;
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int unsigned CTL_W   = $bits(tmr_ctl_t);
  localparam int unsigned REG_MOD = 0;
  localparam int unsigned REG_VAL = 1;
  localparam int unsigned REG_CTL = 2;
  localparam int unsigned REG_STS = 3;
  localparam int unsigned FLAG_CH  = 0;
  localparam int unsigned FLAG_OVF = 1;
  localparam int unsigned NFLAG    = 2;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             center_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    wrap_o = 1'b0;
    if (mod_i == '0) begin
      cnt_d  = '0;
      down_d = 1'b0;
      wrap_o = 1'b1;
    end else if (!center_i) begin
      down_d = 1'b0;
      if (cnt_q >= mod_i) begin
        cnt_d  = '0;
        wrap_o = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (!down_q) begin
      // top of the triangle: overflow on modulus -> modulus-1
      if (cnt_q >= mod_i) begin
        down_d = 1'b1;
        cnt_d  = cnt_q - ONE;
        wrap_o = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == '0) begin
        down_d = 1'b0;
        cnt_d  = ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_in_sync.sv
module tmr_in_sync
  import tmr_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  tmr_edge_e edge_sel_i,
  output logic      hit_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic rd_sts_i,
  input  logic clr_req_i,
  output logic flag_o
);
  logic flag_q, arm_q, clr;

  assign clr = clr_req_i & arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= evt_i | (flag_q & ~clr);
      // a fresh event disarms so the pending write cannot drop it
      if (evt_i || clr)             arm_q <= 1'b0;
      else if (rd_sts_i && flag_q)  arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_MOD = ADDR_W'(REG_MOD);
  localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(REG_VAL);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(REG_CTL);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(REG_STS);

  logic [CNT_W-1:0] mod_q, val_q, cnt;
  tmr_ctl_t         ctl_q;
  logic             oc_q;
  logic             wrap, edge_hit, is_cap, match, cap_evt, ch_evt;
  logic             rd_sts, wr_sts;
  logic [NFLAG-1:0] evt, flag;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .center_i (ctl_q.mode == MODE_CPWM),
    .mod_i    (mod_q),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  tmr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .edge_sel_i (ctl_q.edge_sel),
    .hit_o      (edge_hit)
  );

  assign is_cap  = (ctl_q.mode == MODE_CAP);
  assign match   = (cnt == val_q);
  assign cap_evt = is_cap & edge_hit;
  assign ch_evt  = cap_evt | (~is_cap & match);
  assign rd_sts  = rd_en_i & (addr_i == A_STS);
  assign wr_sts  = wr_en_i & (addr_i == A_STS);

  assign evt[FLAG_CH]  = ch_evt;
  assign evt[FLAG_OVF] = wrap;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    tmr_flag u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt[g]),
      .rd_sts_i  (rd_sts),
      .clr_req_i (wr_sts & ~wdata_i[g]),
      .flag_o    (flag[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= '1;
      val_q <= '0;
      ctl_q <= '0;
      oc_q  <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_MOD) mod_q <= wdata_i;
      if (cap_evt)                         val_q <= cnt;
      else if (wr_en_i && addr_i == A_VAL) val_q <= wdata_i;
      if (wr_en_i && addr_i == A_CTL) ctl_q <= tmr_ctl_t'(wdata_i[CTL_W-1:0]);
      if (ctl_q.mode == MODE_CMP && match) oc_q <= ~oc_q;
    end
  end

  always_comb begin
    unique case (ctl_q.mode)
      MODE_CMP:             pin_o = oc_q;
      MODE_EPWM, MODE_CPWM: pin_o = (cnt < val_q);
      default:              pin_o = 1'b0;
    endcase
  end

  assign pin_oe_o = ~is_cap;
  assign irq_o    = (flag[FLAG_CH] & ctl_q.ch_ie) | (flag[FLAG_OVF] & ctl_q.ovf_ie);

  always_comb begin
    unique case (addr_i)
      A_MOD:   rdata_o = mod_q;
      A_VAL:   rdata_o = val_q;
      A_CTL:   rdata_o = CNT_W'(ctl_q);
      default: rdata_o = CNT_W'(flag);
    endcase
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input tmr_mode_e         mode_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  val_i,
  input logic [CNT_W-1:0]  mod_i,
  input logic              chf_i,
  input logic              ovf_i,
  input logic              wrap_i,
  input logic              cap_i,
  input logic              pin_o_i
);
  // R8
  flag_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chf_i) |-> $past(wr_en_i && addr_i == ADDR_W'(REG_STS) && !wdata_i[0]));

  // R5
  cmp_match_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CMP && cnt_i == val_i) |=> chf_i);

  // R4
  cap_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (val_i == $past(cnt_i)) && chf_i);

  // R3
  center_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CPWM && $past(mode_i) == MODE_CPWM && $stable(mod_i)
     && mod_i != '0 && $past(cnt_i) <= mod_i)
    |-> (cnt_i == CNT_W'($past(cnt_i) + 1'b1) || cnt_i == CNT_W'($past(cnt_i) - 1'b1)));

  // R2
  wrap_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_i);

  // R6
  epwm_start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EPWM && cnt_i == '0 && val_i != '0) |-> pin_o_i);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .mode_i  (ctl_q.mode),
  .cnt_i   (cnt),
  .val_i   (val_q),
  .mod_i   (mod_q),
  .chf_i   (flag[0]),
  .ovf_i   (flag[1]),
  .wrap_i  (wrap),
  .cap_i   (cap_evt),
  .pin_o_i (pin_o)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rdata_o;
  logic        pin_i = 1'b0;
  logic        pin_o, pin_oe_o, irq_o;

  int checks = 0, failures = 0;
  string tag = "R1";

  tmr_channel dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model state
  logic [15:0] m_cnt, m_mod, m_val;
  logic        m_dir, m_oc, m_chf, m_ovf, m_arm_ch, m_arm_ov;
  logic [1:0]  m_mode, m_esel;
  logic        m_chie, m_ovie, m_s1, m_s2, m_prev;

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_mod = 16'hFFFF; m_val = 0; m_dir = 0; m_oc = 0;
    m_chf = 0; m_ovf = 0; m_arm_ch = 0; m_arm_ov = 0;
    m_mode = 0; m_esel = 0; m_chie = 0; m_ovie = 0;
    m_s1 = 0; m_s2 = 0; m_prev = 0;
  endtask

  function automatic logic [15:0] m_rdata(logic [1:0] a);
    case (a)
      2'd0: return m_mod;
      2'd1: return m_val;
      2'd2: return {10'd0, m_ovie, m_chie, m_esel, m_mode};
      default: return {14'd0, m_ovf, m_chf};
    endcase
  endfunction

  function automatic logic m_pin();
    if (m_mode == 2'd1) return m_oc;
    if (m_mode >= 2'd2) return m_cnt < m_val;
    return 1'b0;
  endfunction

  task automatic model_step();
    logic [15:0] ncnt; logic ndir, ovf_e, rise, fall, cap, ch_e, rd3, wr3, clr_c, clr_o;
    ncnt = m_cnt; ndir = m_dir; ovf_e = 0;
    if (m_mod == 0) begin ncnt = 0; ndir = 0; ovf_e = 1; end
    else if (m_mode != 2'd3) begin
      ndir = 0;
      if (m_cnt >= m_mod) begin ncnt = 0; ovf_e = 1; end else ncnt = m_cnt + 1;
    end else if (!m_dir) begin
      if (m_cnt >= m_mod) begin ndir = 1; ncnt = m_cnt - 1; ovf_e = 1; end
      else ncnt = m_cnt + 1;
    end else begin
      if (m_cnt == 0) begin ndir = 0; ncnt = 1; end else ncnt = m_cnt - 1;
    end
    rise = m_s2 & ~m_prev; fall = ~m_s2 & m_prev;
    cap = (m_mode == 2'd0) && ((m_esel == 2'd1 && rise) || (m_esel == 2'd2 && fall) ||
                               (m_esel == 2'd3 && (rise || fall)));
    ch_e = cap || (m_mode != 2'd0 && m_cnt == m_val);
    rd3 = rd_en_i && addr_i == 2'd3;
    wr3 = wr_en_i && addr_i == 2'd3;
    clr_c = wr3 && !wdata_i[0] && m_arm_ch;
    clr_o = wr3 && !wdata_i[1] && m_arm_ov;
    if (ch_e || clr_c) m_arm_ch = 0; else if (rd3 && m_chf) m_arm_ch = 1;
    if (ovf_e || clr_o) m_arm_ov = 0; else if (rd3 && m_ovf) m_arm_ov = 1;
    m_chf = ch_e | (m_chf & ~clr_c);
    m_ovf = ovf_e | (m_ovf & ~clr_o);
    if (m_mode == 2'd1 && m_cnt == m_val) m_oc = ~m_oc;
    if (cap) m_val = m_cnt;
    else if (wr_en_i && addr_i == 2'd1) m_val = wdata_i;
    if (wr_en_i && addr_i == 2'd0) m_mod = wdata_i;
    if (wr_en_i && addr_i == 2'd2) begin
      m_mode = wdata_i[1:0]; m_esel = wdata_i[3:2]; m_chie = wdata_i[4]; m_ovie = wdata_i[5];
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    m_cnt = ncnt; m_dir = ndir;
  endtask

  task automatic compare_all();
    check(tag, "rdata", rdata_o, m_rdata(addr_i));
    check(tag, "pin_o", {15'd0, pin_o}, {15'd0, m_pin()});
    check(tag, "pin_oe", {15'd0, pin_oe_o}, {15'd0, m_mode != 2'd0});
    check("R10", "irq", {15'd0, irq_o}, {15'd0, (m_chf & m_chie) | (m_ovf & m_ovie)});
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    tick();
    wr_en_i = 0;
  endtask

  task automatic rd(logic [1:0] a);
    rd_en_i = 1; addr_i = a;
    tick();
    rd_en_i = 0;
  endtask

  task automatic peek(string req, logic [1:0] a, logic [15:0] exp);
    addr_i = a; #1;
    check(req, "read", rdata_o, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int hi;
    void'($urandom(32'd2468));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset values, R11 map
    peek("R1", 2'd0, 16'hFFFF);
    peek("R1", 2'd1, 16'h0000);
    peek("R1", 2'd2, 16'h0000);
    peek("R1", 2'd3, 16'h0000);
    check("R1", "irq", {15'd0, irq_o}, 16'd0);
    check("R1", "oe", {15'd0, pin_oe_o}, 16'd0);

    // R5 output compare, R2 edge counting
    tag = "R5";
    wr(2'd0, 16'd9);
    wr(2'd1, 16'd4);
    wr(2'd2, 16'h0011);
    run(40);
    // R8: write 0 without arming read leaves flag
    tag = "R8";
    wr(2'd3, 16'd0);
    check("R8", "chf kept", {15'd0, rdata_o[0]}, {15'd0, m_chf});
    peek("R8", 2'd3, m_rdata(2'd3));
    // wait right after a match, arm, clear
    while (m_cnt != 16'd5) tick();
    rd(2'd3);
    wr(2'd3, 16'h0002);
    peek("R8", 2'd3, {14'd0, m_ovf, 1'b0});
    check("R8", "chf cleared model", {15'd0, m_chf}, 16'd0);
    // write of 1 does nothing
    wr(2'd3, 16'h0003);
    run(3);

    // R2 overflow flag in edge mode
    tag = "R2";
    wr(2'd2, 16'h0022);
    run(25);
    check("R2", "ovf set", {15'd0, m_ovf}, 16'd1);

    // R6 edge PWM duty count
    tag = "R6";
    wr(2'd0, 16'd7);
    wr(2'd1, 16'd3);
    run(20);
    hi = 0;
    for (int i = 0; i < 8; i++) begin tick(); hi += pin_o; end
    check("R6", "high cycles", 16'(hi), 16'd3);
    wr(2'd1, 16'd0);
    run(10);
    wr(2'd1, 16'd8);
    run(10);

    // R7 / R3 center PWM
    tag = "R7";
    wr(2'd0, 16'd6);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h0033);
    run(30);
    hi = 0;
    for (int i = 0; i < 12; i++) begin tick(); hi += pin_o; end
    check("R7", "high cycles", 16'(hi), 16'd3);
    tag = "R3";
    run(30);

    // R9 event between read and write keeps flag
    tag = "R9";
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd1);
    run(8);
    while (m_cnt != 16'd2) tick();
    rd(2'd3);        // counter moves 2 -> 1 (match next)
    tick();          // match event here
    wr(2'd3, 16'd0);
    peek("R9", 2'd3, m_rdata(2'd3));
    check("R9", "chf still set", {15'd0, m_chf}, 16'd1);

    // R4 capture on each edge select
    tag = "R4";
    wr(2'd0, 16'hFFFF);
    for (int e = 0; e < 4; e++) begin
      wr(2'd2, 16'(e << 2));
      for (int i = 0; i < 60; i++) begin
        pin_i = $urandom_range(0, 3) == 0 ? ~pin_i : pin_i;
        tick();
      end
      rd(2'd3);
      wr(2'd3, 16'd0);
      run(2);
    end

    // R12 zero modulus
    tag = "R12";
    wr(2'd2, 16'h0021);
    wr(2'd0, 16'd0);
    run(5);
    check("R12", "ovf", {15'd0, m_ovf}, 16'd1);
    check("R12", "cnt", m_cnt, 16'd0);

    // R11 random traffic
    tag = "R11";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      wr_en_i = (r < 2);
      rd_en_i = (r >= 2 && r < 5);
      addr_i = 2'($urandom_range(0, 3));
      wdata_i = 16'($urandom_range(0, 15));
      if (wr_en_i && addr_i == 2'd2) wdata_i = 16'($urandom_range(0, 63));
      if (wr_en_i && addr_i == 2'd0 && $urandom_range(0, 7) == 0) wdata_i = 0;
      if ($urandom_range(0, 4) == 0) pin_i = ~pin_i;
      tick();
    end
    wr_en_i = 0; rd_en_i = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule